// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is the command front end and embedded-operation sequencer of a byte-wide NOR flash with a 19-bit address and eight equal sectors, where the top three address bits pick the sector. Host bus writes, sampled on the rising clock edge while chip and write enables are low, go through a command decoder. The decoder recognises programming, sector erase (one or many sectors), whole-chip erase, erase suspend, erase resume and a return to read mode. The controller then runs timed program and erase passes against an internal array model, which holds 2^ROW_W bytes per sector. Offset bits above ROW_W are ignored by the model, and a full-size build sets ROW_W to 16.

While an operation runs, host reads return a status byte instead of array data. In the status byte, bit 7 is a data-polling flag, bit 6 flips on every status read, and bit 2 flips only when the addressed sector is part of the erase set. A hardware protection mask, with one bit per sector, shields sectors from both program and erase. A sector erase can be paused so that the host can read or program sectors outside the erase set, and then continued.

The bus is plain control with no valid/ready handshake. Every access completes in the cycle it is presented, so there is no back-pressure. A write cycle is ce_n=0, we_n=0, oe_n=1. A read cycle is ce_n=0, oe_n=0, we_n=1, and rdata is valid combinationally during that cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF and the controller is in read mode. Outside a read cycle rdata is 0x00.
- R2: Writes of 0xAA to 0x555, 0x55 to 0x2AA and 0xA0 to 0x555, where only address bits 10:0 are compared, followed by a write of address and data, program that byte. The address and data are taken from that last write cycle. When the program completes the byte holds old AND data.
- R3: While a program runs, every read returns status: bit 7 is the complement of bit 7 of the data being written, and bit 6 differs between consecutive reads.
- R4: Unlock, 0x80, unlock, then 0x30 written to an address in each chosen sector starts a sector erase. Each further 0x30 write arriving within SEL_WIN idle cycles of the previous one adds its sector. The chosen unprotected sectors then read 0xFF, and other sectors keep their data.
- R5: Unlock, 0x80, unlock, then 0x10 to 0x555 erases every unprotected sector.
- R6: A program or erase aimed at a sector whose prot_mask bit is 1 is ignored. Its data is unchanged, and a program to it does not make reads return status.
- R7: While an erase runs (not suspended), status bit 7 reads 0. Bit 2 differs between consecutive reads of a sector in the erase set and stays constant for reads of other sectors.
- R8: A write of 0xB0 during a running erase suspends it. While suspended, reads of sectors outside the erase set return array data. Reads inside the set return status with bit 7 = 1, bit 6 constant and bit 2 differing between consecutive reads.
- R9: While suspended, a program to a sector outside the erase set executes normally, and a program to a sector inside the set is ignored.
- R10: While suspended, a write of 0x30 to any address resumes the erase, which then completes.
- R11: A write that breaks the unlock prefix, or a 0xF0 write, returns the decoder to read mode, so the following writes program nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 19 | Byte address; bits 18:16 select the sector |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Array data or status byte during a read cycle, else 0 |
| prot_mask | input | 8 | Per-sector protection, 1 = protected |

## Verification
The assertions assume that prot_mask changes only while no program or erase is pending. They also assume that a bus cycle never asserts write and output enables together. The stimulus sets the protection mask only between operations, after the host has polled a finished operation back to read mode. Each write or read strobe lasts exactly one clock and is followed by an idle clock, so the flip of the toggle bits is observed once per access.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int ADDR_W = 19;
  localparam int SEC_W  = 3;
  localparam int NSEC   = 8;
  localparam int DATA_W = 8;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_PAUSE = 8'hB0;
  localparam logic [7:0] CMD_GO_ON = 8'h30;
  localparam logic [7:0] CMD_READ  = 8'hF0;

  localparam logic [10:0] KEY_ADR1 = 11'h555;
  localparam logic [10:0] KEY_ADR2 = 11'h2AA;

  typedef enum logic [2:0] {
    D_RD, D_K1, D_K2, D_PROG, D_E0, D_E1, D_E2, D_COLL
  } dec_st_t;

  typedef enum logic [1:0] {
    EP_PRE, EP_WAIT, EP_WIPE, EP_CHECK
  } eph_t;
endpackage

// File: rtl/flash_array.sv
module flash_array
  import flash_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_pkg::*;
#(
  parameter int SEL_WIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSEC-1:0]   prot_mask,
  input  logic              prog_act,
  input  logic              erase_act,
  input  logic              susp,
  input  logic [NSEC-1:0]   sel_mask,
  output logic              prog_go,
  output logic              erase_go,
  output logic [NSEC-1:0]   erase_mask,
  output logic              susp_go,
  output logic              resume_go
);
  localparam int WIN_W = $clog2(SEL_WIN) + 1;

  dec_st_t           st, st_n;
  logic [NSEC-1:0]   coll, coll_n;
  logic [WIN_W-1:0]  win, win_n;

  logic [SEC_W-1:0]  sec;
  logic [NSEC-1:0]   sec_bit;
  logic              at1, at2;

  assign sec     = addr[ADDR_W-1 -: SEC_W];
  assign sec_bit = NSEC'(1) << sec;
  assign at1     = (addr[10:0] == KEY_ADR1);
  assign at2     = (addr[10:0] == KEY_ADR2);

  always_comb begin
    st_n       = st;
    coll_n     = coll;
    win_n      = win;
    prog_go    = 1'b0;
    erase_go   = 1'b0;
    erase_mask = '0;
    susp_go    = 1'b0;
    resume_go  = 1'b0;
    if (prog_act) begin
      st_n = D_RD;
    end else if (erase_act && !susp) begin
      st_n = D_RD;
      if (wr && wdata == CMD_PAUSE) susp_go = 1'b1;
    end else if (st == D_COLL && !wr) begin
      if (win == WIN_W'(SEL_WIN - 1)) begin
        st_n       = D_RD;
        erase_mask = coll & ~prot_mask;
        erase_go   = |erase_mask;
      end else begin
        win_n = win + 1'b1;
      end
    end else if (wr) begin
      if (wdata == CMD_READ && st != D_PROG) begin
        st_n = D_RD;
      end else begin
        case (st)
          D_RD: begin
            if (wdata == CMD_KEY1 && at1) st_n = D_K1;
            else if (susp && wdata == CMD_GO_ON) resume_go = 1'b1;
          end
          D_K1: st_n = (wdata == CMD_KEY2 && at2) ? D_K2 : D_RD;
          D_K2: begin
            if (wdata == CMD_PROG && at1) st_n = D_PROG;
            else if (wdata == CMD_ERASE && at1 && !erase_act) st_n = D_E0;
            else st_n = D_RD;
          end
          D_PROG: begin
            st_n    = D_RD;
            prog_go = !prot_mask[sec] && !(susp && sel_mask[sec]);
          end
          D_E0: st_n = (wdata == CMD_KEY1 && at1) ? D_E1 : D_RD;
          D_E1: st_n = (wdata == CMD_KEY2 && at2) ? D_E2 : D_RD;
          D_E2: begin
            if (wdata == CMD_CHIP && at1) begin
              st_n       = D_RD;
              erase_mask = ~prot_mask;
              erase_go   = |erase_mask;
            end else if (wdata == CMD_SECT) begin
              st_n   = D_COLL;
              coll_n = sec_bit;
              win_n  = '0;
            end else begin
              st_n = D_RD;
            end
          end
          D_COLL: begin
            if (wdata == CMD_SECT) begin
              coll_n = coll | sec_bit;
              win_n  = '0;
            end else begin
              st_n = D_RD;
            end
          end
          default: st_n = D_RD;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= D_RD;
      coll <= '0;
      win  <= '0;
    end else begin
      st   <= st_n;
      coll <= coll_n;
      win  <= win_n;
    end
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_pkg::*;
#(
  parameter int ROW_W     = 6,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_go,
  input  logic [SEC_W+ROW_W-1:0]   go_idx,
  input  logic [DATA_W-1:0]        go_data,
  input  logic                     erase_go,
  input  logic [NSEC-1:0]          erase_mask,
  input  logic                     susp_go,
  input  logic                     resume_go,
  output logic                     prog_act,
  output logic                     erase_act,
  output logic                     susp,
  output logic [NSEC-1:0]          sel_mask,
  output logic                     prog_d7n,
  output logic                     arr_we,
  output logic [SEC_W+ROW_W-1:0]   arr_waddr,
  output logic [DATA_W-1:0]        arr_wdata,
  output logic [SEC_W+ROW_W-1:0]   arr_raddr,
  input  logic [DATA_W-1:0]        arr_rdata
);
  localparam int IDX_W = SEC_W + ROW_W;
  localparam int PC_W  = $clog2(PROG_CYC) + 1;
  localparam int EC_W  = $clog2(ERASE_CYC) + 1;

  logic [PC_W-1:0]   pcnt;
  logic [IDX_W-1:0]  pidx;
  logic [DATA_W-1:0] pdata;
  logic [NSEC-1:0]   pend, pend_left;
  eph_t              ph;
  logic [ROW_W-1:0]  bidx;
  logic [EC_W-1:0]   wcnt;
  logic [SEC_W-1:0]  cur_sec;
  logic              erun, p_fire, b_last;

  always_comb begin
    cur_sec = '0;
    for (int i = NSEC - 1; i >= 0; i--) begin
      if (pend[i]) cur_sec = SEC_W'(i);
    end
  end

  assign pend_left = pend & ~(NSEC'(1) << cur_sec);
  assign erun      = erase_act && !susp && !prog_act;
  assign p_fire    = prog_act && (pcnt == PC_W'(PROG_CYC - 1));
  assign b_last    = &bidx;
  assign prog_d7n  = ~pdata[DATA_W-1];
  assign arr_raddr = prog_act ? pidx : {cur_sec, bidx};

  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = {cur_sec, bidx};
    arr_wdata = '0;
    if (p_fire) begin
      arr_we    = 1'b1;
      arr_waddr = pidx;
      arr_wdata = arr_rdata & pdata;
    end else if (erun && ph == EP_PRE) begin
      arr_we    = 1'b1;
      arr_wdata = '0;
    end else if (erun && ph == EP_WIPE) begin
      arr_we    = 1'b1;
      arr_wdata = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_act <= 1'b0;
      pcnt     <= '0;
      pidx     <= '0;
      pdata    <= '0;
    end else if (prog_go) begin
      prog_act <= 1'b1;
      pcnt     <= '0;
      pidx     <= go_idx;
      pdata    <= go_data;
    end else if (prog_act) begin
      if (p_fire) prog_act <= 1'b0;
      else        pcnt     <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      susp <= 1'b0;
    end else if (susp_go && erase_act && !susp && !prog_act) begin
      susp <= 1'b1;
    end else if (resume_go && susp && !prog_act) begin
      susp <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_act <= 1'b0;
      sel_mask  <= '0;
      pend      <= '0;
      ph        <= EP_PRE;
      bidx      <= '0;
      wcnt      <= '0;
    end else if (erase_go) begin
      erase_act <= 1'b1;
      sel_mask  <= erase_mask;
      pend      <= erase_mask;
      ph        <= EP_PRE;
      bidx      <= '0;
      wcnt      <= '0;
    end else if (erun) begin
      case (ph)
        EP_PRE: begin
          bidx <= bidx + 1'b1;
          if (b_last) begin
            ph   <= EP_WAIT;
            wcnt <= '0;
          end
        end
        EP_WAIT: begin
          if (wcnt == EC_W'(ERASE_CYC - 1)) ph <= EP_WIPE;
          else wcnt <= wcnt + 1'b1;
        end
        EP_WIPE: begin
          bidx <= bidx + 1'b1;
          if (b_last) ph <= EP_CHECK;
        end
        EP_CHECK: begin
          if (arr_rdata != '1) begin
            ph   <= EP_WIPE;
            bidx <= '0;
          end else begin
            bidx <= bidx + 1'b1;
            if (b_last) begin
              pend <= pend_left;
              if (pend_left == '0) begin
                erase_act <= 1'b0;
                sel_mask  <= '0;
              end else begin
                ph <= EP_PRE;
              end
            end
          end
        end
        default: ph <= EP_PRE;
      endcase
    end
  end
endmodule

// File: rtl/flash_status.sv
module flash_status
  import flash_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [SEC_W-1:0]  rd_sec,
  input  logic              prog_act,
  input  logic              erase_act,
  input  logic              susp,
  input  logic [NSEC-1:0]   sel_mask,
  input  logic              prog_d7n,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rdata
);
  logic t6, t2;
  logic sel_hit, run_busy, show_stat, dq7;

  assign sel_hit   = erase_act && sel_mask[rd_sec];
  assign run_busy  = prog_act || (erase_act && !susp);
  assign show_stat = run_busy || sel_hit;
  assign dq7       = prog_act ? prog_d7n : !(erase_act && !susp);

  always_comb begin
    if (!rd)            rdata = '0;
    else if (show_stat) rdata = {dq7, t6, 3'b000, t2, 2'b00};
    else                rdata = arr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t6 <= 1'b0;
      t2 <= 1'b0;
    end else if (rd && show_stat) begin
      if (run_busy) t6 <= ~t6;
      if (sel_hit)  t2 <= ~t2;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int ROW_W     = 6,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 16,
  parameter int SEL_WIN   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSEC-1:0]   prot_mask
);
  localparam int IDX_W = SEC_W + ROW_W;

  logic              wr_stb, rd_stb;
  logic [SEC_W-1:0]  bus_sec;
  logic [IDX_W-1:0]  bus_idx;
  logic              prog_go, erase_go, susp_go, resume_go;
  logic [NSEC-1:0]   erase_mask, sel_mask;
  logic              prog_act, erase_act, susp, prog_d7n;
  logic              arr_we;
  logic [IDX_W-1:0]  arr_waddr, arr_raddr;
  logic [DATA_W-1:0] arr_wdata, arr_rdata_b, arr_rdata_a;
  logic [SEC_W-1:0]  arr_wsec;

  assign wr_stb   = !ce_n && !we_n && oe_n;
  assign rd_stb   = !ce_n && !oe_n && we_n;
  assign bus_sec  = addr[ADDR_W-1 -: SEC_W];
  assign bus_idx  = {bus_sec, addr[ROW_W-1:0]};
  assign arr_wsec = arr_waddr[IDX_W-1 -: SEC_W];

  flash_cmd_decode #(.SEL_WIN(SEL_WIN)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(wr_stb), .addr(addr), .wdata(wdata),
    .prot_mask(prot_mask), .prog_act(prog_act), .erase_act(erase_act),
    .susp(susp), .sel_mask(sel_mask), .prog_go(prog_go), .erase_go(erase_go),
    .erase_mask(erase_mask), .susp_go(susp_go), .resume_go(resume_go)
  );

  flash_seq #(.ROW_W(ROW_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .go_idx(bus_idx),
    .go_data(wdata), .erase_go(erase_go), .erase_mask(erase_mask),
    .susp_go(susp_go), .resume_go(resume_go), .prog_act(prog_act),
    .erase_act(erase_act), .susp(susp), .sel_mask(sel_mask),
    .prog_d7n(prog_d7n), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata_b)
  );

  flash_array #(.IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .raddr_a(bus_idx), .rdata_a(arr_rdata_a),
    .raddr_b(arr_raddr), .rdata_b(arr_rdata_b), .we(arr_we),
    .waddr(arr_waddr), .wdata(arr_wdata)
  );

  flash_status u_stat (
    .clk(clk), .rst_n(rst_n), .rd(rd_stb), .rd_sec(bus_sec),
    .prog_act(prog_act), .erase_act(erase_act), .susp(susp),
    .sel_mask(sel_mask), .prog_d7n(prog_d7n), .arr_data(arr_rdata_a),
    .rdata(rdata)
  );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd,
  input logic [DATA_W-1:0] rdata,
  input logic [NSEC-1:0]   prot_mask,
  input logic              prog_act,
  input logic              erase_act,
  input logic              susp,
  input logic [NSEC-1:0]   sel_mask,
  input logic              arr_we,
  input logic [SEC_W-1:0]  arr_wsec
);
  assert_prot_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !prot_mask[arr_wsec]);

  assert_prog_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && prog_act && $past(rd && prog_act)) |-> rdata[6] != $past(rdata[6]));

  assert_erase_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && erase_act && !susp && !prog_act) |-> rdata[7] == 1'b0);

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && !prog_act) |-> !arr_we);

  assert_susp_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && susp) |-> !sel_mask[arr_wsec]);

  assert_one_engine_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_act && erase_act) |-> susp);

  assert_resume_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(susp) |-> erase_act);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd_stb), .rdata(rdata),
  .prot_mask(prot_mask), .prog_act(prog_act), .erase_act(erase_act),
  .susp(susp), .sel_mask(sel_mask), .arr_we(arr_we), .arr_wsec(arr_wsec)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int ROW_W = 6, PROG_CYC = 12, ERASE_CYC = 16, SEL_WIN = 16;
  localparam int ROWS = 2 ** ROW_W;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0, prot = 8'h00;
  logic [7:0]  rdata;

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.ROW_W(ROW_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                   .SEL_WIN(SEL_WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .prot_mask(prot));

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [8*ROWS];

  function automatic int midx(logic [18:0] a);
    return int'(a[18:16]) * ROWS + int'(a[ROW_W-1:0]);
  endfunction

  function automatic logic [18:0] mk(int s, int o);
    return {3'(s), 16'(o)};
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [18:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_rd(logic [18:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #2 d = rdata;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock();
    bus_wr(19'h555, 8'hAA);
    bus_wr(19'h2AA, 8'h55);
  endtask

  task automatic do_prog(logic [18:0] a, logic [7:0] d);
    unlock();
    bus_wr(19'h555, 8'hA0);
    bus_wr(a, d);
  endtask

  task automatic model_prog(logic [18:0] a, logic [7:0] d);
    if (!prot[a[18:16]]) model[midx(a)] = model[midx(a)] & d;
  endtask

  task automatic model_erase(logic [7:0] m);
    for (int s = 0; s < 8; s++)
      if (m[s] && !prot[s])
        for (int o = 0; o < ROWS; o++) model[s*ROWS+o] = 8'hFF;
  endtask

  task automatic wait_done(logic [18:0] a, string req);
    logic [7:0] x, y;
    bit ok;
    ok = 1'b0;
    bus_rd(a, x);
    for (int n = 0; n < 4000; n++) begin
      bus_rd(a, y);
      if (x == y) begin ok = 1'b1; break; end
      x = y;
    end
    if (!ok) chk(1'b0, {req, " completion"}, y, x);
  endtask

  task automatic check_rd(logic [18:0] a, string req);
    logic [7:0] v;
    bus_rd(a, v);
    chk(v == model[midx(a)], req, v, model[midx(a)]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] v1, v2;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8*ROWS; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: erased after reset, idle output zero
    @(negedge clk); #2;
    chk(rdata == 8'h00, "R1 idle rdata", rdata, 8'h00);
    check_rd(mk(0, 5), "R1 reset read");
    check_rd(mk(6, 63), "R1 reset read");

    // R2/R3: program with status polling
    do_prog(mk(0, 8'h12), 8'h5A);
    model_prog(mk(0, 8'h12), 8'h5A);
    bus_rd(mk(3, 1), v1);
    chk(v1[7] == 1'b1, "R3 poll bit7", v1, {1'b1, v1[6:0]});
    bus_rd(mk(3, 1), v2);
    chk(v2[6] != v1[6], "R3 toggle bit6", v2, {v2[7], ~v1[6], v2[5:0]});
    wait_done(mk(0, 8'h12), "R2");
    check_rd(mk(0, 8'h12), "R2 program");
    do_prog(mk(0, 8'h12), 8'h0F);
    model_prog(mk(0, 8'h12), 8'h0F);
    wait_done(mk(0, 8'h12), "R2");
    check_rd(mk(0, 8'h12), "R2 AND rule");

    // sector 7 content, then protect it
    do_prog(mk(7, 3), 8'h3C);
    model_prog(mk(7, 3), 8'h3C);
    wait_done(mk(7, 3), "R6");
    prot = 8'h80;

    // R6: program to protected sector ignored, not busy
    do_prog(mk(7, 3), 8'h00);
    bus_rd(mk(7, 3), v1);
    chk(v1 == 8'h3C, "R6 protected program", v1, 8'h3C);

    // R11: broken prefix and read-reset
    bus_wr(19'h555, 8'hAA);
    bus_wr(19'h2AB, 8'h55);
    bus_wr(19'h555, 8'hA0);
    bus_wr(mk(0, 8'h12), 8'h00);
    check_rd(mk(0, 8'h12), "R11 broken prefix");
    unlock();
    bus_wr(19'h555, 8'hF0);
    bus_wr(19'h555, 8'hA0);
    bus_wr(mk(0, 8'h12), 8'h00);
    check_rd(mk(0, 8'h12), "R11 reset command");

    // R4/R7: multi-sector erase (1, 3, protected 7)
    do_prog(mk(1, 4), 8'h11); model_prog(mk(1, 4), 8'h11); wait_done(mk(1, 4), "R4");
    do_prog(mk(2, 4), 8'h22); model_prog(mk(2, 4), 8'h22); wait_done(mk(2, 4), "R4");
    do_prog(mk(3, 9), 8'h33); model_prog(mk(3, 9), 8'h33); wait_done(mk(3, 9), "R4");
    unlock(); bus_wr(19'h555, 8'h80); unlock();
    bus_wr(mk(1, 0), 8'h30);
    bus_wr(mk(3, 0), 8'h30);
    bus_wr(mk(7, 0), 8'h30);
    repeat (SEL_WIN + 4) @(negedge clk);
    bus_rd(mk(1, 4), v1);
    chk(v1[7] == 1'b0, "R7 erase poll", v1, {1'b0, v1[6:0]});
    bus_rd(mk(1, 4), v2);
    chk(v2[2] != v1[2], "R7 bit2 selected", v2, {v2[7:3], ~v1[2], v2[1:0]});
    bus_rd(mk(2, 4), v1);
    bus_rd(mk(2, 4), v2);
    chk(v2[2] == v1[2] && v2[6] != v1[6], "R7 bit2 other", v2, {v2[7], ~v1[6], v2[5:3], v1[2], v2[1:0]});
    wait_done(mk(2, 4), "R4");
    model_erase(8'h8A);
    check_rd(mk(1, 4), "R4 erased s1");
    check_rd(mk(3, 9), "R4 erased s3");
    check_rd(mk(2, 4), "R4 kept s2");
    check_rd(mk(7, 3), "R6 protected erase");

    // R8/R9/R10: suspend and resume
    do_prog(mk(4, 6), 8'h44); model_prog(mk(4, 6), 8'h44); wait_done(mk(4, 6), "R8");
    do_prog(mk(5, 6), 8'h55); model_prog(mk(5, 6), 8'h55); wait_done(mk(5, 6), "R8");
    unlock(); bus_wr(19'h555, 8'h80); unlock();
    bus_wr(mk(4, 0), 8'h30);
    repeat (SEL_WIN + 10) @(negedge clk);
    bus_wr(mk(0, 0), 8'hB0);
    check_rd(mk(5, 6), "R8 suspended read");
    bus_rd(mk(4, 6), v1);
    bus_rd(mk(4, 6), v2);
    chk(v1[7] == 1'b1, "R8 suspended bit7", v1, {1'b1, v1[6:0]});
    chk(v2[6] == v1[6] && v2[2] != v1[2], "R8 suspended toggles", v2, {v2[7], v1[6], v2[5:3], ~v1[2], v2[1:0]});
    do_prog(mk(5, 7), 8'hA5); model_prog(mk(5, 7), 8'hA5);
    wait_done(mk(5, 7), "R9");
    check_rd(mk(5, 7), "R9 program in suspend");
    do_prog(mk(4, 6), 8'h00);
    check_rd(mk(5, 6), "R9 selected program ignored");
    bus_wr(mk(2, 0), 8'h30);
    wait_done(mk(4, 6), "R10");
    model_erase(8'h10);
    check_rd(mk(4, 6), "R10 resumed erase");
    check_rd(mk(5, 7), "R10 kept s5");

    // R5: chip erase
    unlock(); bus_wr(19'h555, 8'h80); unlock();
    bus_wr(19'h555, 8'h10);
    wait_done(mk(0, 1), "R5");
    model_erase(8'hFF);
    check_rd(mk(0, 8'h12), "R5 chip erase");
    check_rd(mk(5, 7), "R5 chip erase");
    check_rd(mk(7, 3), "R6 protected chip erase");

    // random programs and reads (R2, R6)
    for (int k = 0; k < 40; k++) begin
      logic [18:0] a;
      logic [7:0]  d;
      a = mk(int'($urandom % 8), int'($urandom % ROWS));
      d = 8'($urandom);
      do_prog(a, d);
      model_prog(a, d);
      wait_done(a, "R2");
      check_rd(a, prot[a[18:16]] ? "R6 random" : "R2 random");
      check_rd(mk(int'($urandom % 8), int'($urandom % ROWS)), "R2 random read");
    end

    report();
  end
endmodule